// File: doc/BRIEF.md
# Receive Back-Pressure Jam Controller

This block watches how much free space is left in a receive buffer and asks the transmit MAC to send a jam when that space runs low. A high-water threshold, counted in kilobytes of free space, sets the trip point. While the free byte count stays under that trip point, the block keeps a jam request high for a programmed length of time. That length is picked from a fixed set of microsecond values. A clock-rate parameter turns microseconds into clock cycles.

An 8-bit configuration register sets the behaviour and can be written and read back. The upper nibble is the threshold in 1 KB units. The lower nibble is a code that selects the jam length. When a jam period ends and the buffer is still short of space, the next period starts with no gap. The duration of each period is captured when that period starts. A threshold of zero turns back-pressure off.

The block has no streaming data path. All of its pins are plain control and status signals, so it needs no valid/ready handshake.

Top module: `bp_jam_ctrl`

## Requirements
- R1: The configuration register resets to 0x37, which is threshold 3 and duration code 7. A write with `cfg_wr` high is visible on `cfg_rdata` from the next cycle.
- R2: The threshold is `cfg_rdata[7:4]`, in units of 1024 bytes. When the threshold is nonzero and `free_bytes` is strictly below threshold×1024 while no jam is running, `jam_req` rises on the next cycle. A free count equal to threshold×1024 starts no jam.
- R3: Every jam period lasts exactly D×`CYC_PER_US` cycles. D is chosen by `cfg_rdata[3:0]`: codes 0 to 4 give 5, 10, 15, 25 and 50 µs. Code c from 5 to 15 gives 100+50×(c−5) µs, ending at 600 µs for code 15.
- R4: A threshold of 0 never starts a jam, whatever the free count.
- R5: If the free count is still below the threshold at the last cycle of a period, a new period starts at once. `jam_req` stays high with no low cycle.
- R6: A duration code written while a period is running does not change that period. It applies from the next period.
- R7: `busy` is high in any cycle where `jam_req` is high or the below-threshold condition of R2 holds.
- R8: Reset clears `jam_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data: [7:4] threshold, [3:0] duration code |
| cfg_rdata | output | 8 | Current configuration register value |
| free_bytes | input | FREE_W | Free space in the receive buffer, in bytes |
| jam_req | output | 1 | Jam request to the transmit MAC |
| busy | output | 1 | Jam running or below-threshold condition present |

## Verification
The assertions assume that `free_bytes` is a settled value that changes only between clock edges. They also assume that `cfg_wdata` is meaningful only while `cfg_wr` is high. The minimum-length check assumes that `CYC_PER_US` is at least 1.

The stimulus drives every input at the falling edge. Each measurement starts by raising the free count above any threshold, which guarantees an idle start. The random free counts are drawn either strictly below or at/above the programmed limit, never from an undefined range.

// File: rtl/bpj_pkg.sv
package bpj_pkg;
  localparam int THR_W  = 4;
  localparam int CODE_W = 4;
  localparam int US_W   = 10;
  localparam int KB_SHIFT = 10;

  typedef enum logic {ST_IDLE = 1'b0, ST_JAM = 1'b1} bpj_state_e;

  function automatic logic [US_W-1:0] jam_us(input logic [CODE_W-1:0] code);
    int us;
    case (code)
      4'd0:    us = 5;
      4'd1:    us = 10;
      4'd2:    us = 15;
      4'd3:    us = 25;
      4'd4:    us = 50;
      default: us = 100 + (int'(code) - 5) * 50;
    endcase
    return US_W'(us);
  endfunction
endpackage

// File: rtl/bpj_thresh.sv
module bpj_thresh #(
  parameter int FREE_W = 16
) (
  input  logic [bpj_pkg::THR_W-1:0] thr,
  input  logic [FREE_W-1:0]         free_bytes,
  output logic                      below
);
  localparam int LIM_W = bpj_pkg::THR_W + bpj_pkg::KB_SHIFT;
  localparam int CMP_W = (FREE_W > LIM_W) ? FREE_W : LIM_W;

  logic [LIM_W-1:0] limit;
  logic [CMP_W-1:0] free_x, lim_x;

  always_comb begin
    limit  = {thr, {bpj_pkg::KB_SHIFT{1'b0}}};
    free_x = CMP_W'(free_bytes);
    lim_x  = CMP_W'(limit);
    below  = (thr != '0) && (free_x < lim_x);
  end
endmodule

// File: rtl/bpj_timer.sv
module bpj_timer #(
  parameter int CYC_PER_US = 100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     load,
  input  logic [bpj_pkg::US_W-1:0] load_us,
  output logic                     done
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0]         pre_q;
  logic [bpj_pkg::US_W-1:0] us_q;

  assign done = run && (pre_q == '0) && (us_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (load) begin
      pre_q <= PRE_MAX;
      us_q  <= load_us - 1'b1;
    end else if (run) begin
      if (pre_q == '0) begin
        pre_q <= PRE_MAX;
        if (us_q != '0) us_q <= us_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bp_jam_ctrl.sv
module bp_jam_ctrl #(
  parameter int CYC_PER_US = 100,
  parameter int FREE_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [FREE_W-1:0] free_bytes,
  output logic              jam_req,
  output logic              busy
);
  import bpj_pkg::*;

  localparam logic [7:0] CFG_RST = 8'h37;

  logic [7:0]  cfg_q;
  bpj_state_e  state_q;
  logic        below, done, start;

  bpj_thresh #(.FREE_W(FREE_W)) u_thresh (
    .thr        (cfg_q[7:4]),
    .free_bytes (free_bytes),
    .below      (below)
  );

  assign start = below && ((state_q == ST_IDLE) || done);

  bpj_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_JAM),
    .load    (start),
    .load_us (jam_us(cfg_q[3:0])),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else if (cfg_wr) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else if (start) state_q <= ST_JAM;
    else if (done) state_q <= ST_IDLE;
  end

  assign cfg_rdata = cfg_q;
  assign jam_req   = (state_q == ST_JAM);
  assign busy      = jam_req | below;
endmodule

// File: rtl/bpj_checker.sv
module bpj_checker #(
  parameter int CYC_PER_US = 100,
  parameter int FREE_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic [FREE_W-1:0] free_bytes,
  input logic              jam_req,
  input logic              busy
);
  localparam int MIN_LEN = 5 * CYC_PER_US;
  logic low_space;
  int   run_len;

  assign low_space = (cfg_rdata[7:4] != 4'd0) &&
                     ({16'd0, free_bytes} < ({{(FREE_W+2){1'b0}}, cfg_rdata[7:4]} << 10));

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= 0;
    else if (jam_req) run_len <= run_len + 1;
    else run_len <= 0;
  end

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata))); // R1
  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_req && low_space) |=> jam_req); // R2
  AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_req && $past(jam_req)) |-> (run_len >= MIN_LEN)); // R3
  AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_req && cfg_rdata[7:4] == 4'd0) |=> !jam_req); // R4
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_req || low_space) |-> busy); // R7
endmodule

bind bp_jam_ctrl bpj_checker #(.CYC_PER_US(CYC_PER_US), .FREE_W(FREE_W)) u_bpj_checker (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .free_bytes(free_bytes), .jam_req(jam_req), .busy(busy)
);

// File: tb/bp_jam_ctrl_bench.sv
module bp_jam_ctrl_bench;
  localparam int CYC = 2;
  localparam int FW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_rdata;
  logic [FW-1:0] free_bytes = 16'hFFFF;
  logic          jam_req, busy;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bp_jam_ctrl #(.CYC_PER_US(CYC), .FREE_W(FW)) u_bp_jam_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .free_bytes(free_bytes), .jam_req(jam_req), .busy(busy)
  );

  function automatic int exp_us(input int code);
    int t[5] = '{5, 10, 15, 25, 50};
    if (code < 5) return t[code];
    return 100 + 50 * (code - 5);
  endfunction

  function automatic int exp_len(input int code);
    return exp_us(code) * CYC;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic settle_idle();
    free_bytes = 16'hFFFF;
    for (int i = 0; i < 1300 && jam_req; i++) @(negedge clk);
    @(negedge clk);
  endtask

  // Drive a low free count once; return the length of the single jam period, -1 if none.
  task automatic one_jam(input logic [15:0] fr, output int len);
    @(negedge clk); free_bytes = fr;
    @(negedge clk);
    if (!jam_req) begin
      len = -1;
      free_bytes = 16'hFFFF;
    end else begin
      free_bytes = 16'hFFFF;
      len = 1;
      for (int i = 0; i < 1400; i++) begin
        @(negedge clk);
        if (!jam_req) break;
        len++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 jam_req after reset", jam_req, 0);
    check("R1 reset config", cfg_rdata, 8'h37);
    check("R7 busy idle with space", busy, 0);

    // R2 boundary: equal to limit (3 KB) starts nothing
    @(negedge clk); free_bytes = 16'd3072;
    repeat (3) @(negedge clk);
    check("R2 equal to limit no jam", jam_req, 0);
    // R7 busy follows the condition combinationally
    free_bytes = 16'd3071; #1;
    check("R7 busy on low space", busy, 1);
    settle_idle();

    // R2 + R3 default code 7 => 200 us
    one_jam(16'd3071, len);
    check("R3 default duration", len, exp_len(7));

    // R1 write/readback
    wr_cfg(8'h50);
    check("R1 readback", cfg_rdata, 8'h50);

    // R3 every code
    for (int c = 0; c < 16; c++) begin
      wr_cfg(8'(8'h50 | c));
      settle_idle();
      one_jam(16'd100, len);
      check($sformatf("R3 code %0d", c), len, exp_len(c));
    end

    // R4 threshold 0
    wr_cfg(8'h03);
    settle_idle();
    @(negedge clk); free_bytes = 16'd0;
    repeat (5) @(negedge clk);
    check("R4 zero threshold jam", jam_req, 0);
    check("R4 zero threshold busy", busy, 0);
    free_bytes = 16'hFFFF;

    // R5 retrigger: code 0 => 10 cycles, hold low for 3 periods
    wr_cfg(8'h20);
    settle_idle();
    @(negedge clk); free_bytes = 16'd10;
    @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 3 * exp_len(0); i++) begin
        if (jam_req) hi++;
        @(negedge clk);
      end
      check("R5 continuous jam", hi, 3 * exp_len(0));
    end
    settle_idle();

    // R6 mid-period config change
    @(negedge clk); free_bytes = 16'd10;
    @(negedge clk); free_bytes = 16'hFFFF;
    len = 1;
    @(negedge clk); len++;
    cfg_wr = 1'b1; cfg_wdata = 8'h2F;
    @(negedge clk); cfg_wr = 1'b0; len++;
    for (int i = 0; i < 1400; i++) begin
      @(negedge clk);
      if (!jam_req) break;
      len++;
    end
    check("R6 running period unchanged", len, exp_len(0));
    settle_idle();
    one_jam(16'd10, len);
    check("R6 next period uses new code", len, exp_len(15));

    // random mix
    for (int k = 0; k < 20; k++) begin
      int thr  = 1 + ($urandom % 15);
      int code = $urandom % 16;
      int lim  = thr * 1024;
      logic hit = ($urandom % 2) == 1;
      logic [15:0] fr = hit ? 16'($urandom % lim) : 16'(lim + ($urandom % (65536 - lim)));
      wr_cfg(8'((thr << 4) | code));
      settle_idle();
      one_jam(fr, len);
      if (hit) check($sformatf("R2 R3 random thr=%0d code=%0d", thr, code), len, exp_len(code));
      else     check($sformatf("R2 random no jam thr=%0d free=%0d", thr, fr), len, -1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule